// File: doc/BRIEF.md
# Clear-on-Read Interrupt Aggregator

This block gathers up to 32 single-cycle event inputs into four byte-wide flag registers. Each flag register has its own byte-wide enable register. The enabled flags are combined into one pending indication, which drives an active-low interrupt line to a host. A global enable in a configuration register masks that line. The host reaches every register through a simple byte port: an address, a read strobe, a write strobe and byte-wide write and read data.

The host services an interrupt by reading each flag register. A read returns the flags and clears them in the same access. Flags of enabled sources keep latching while the global enable is off, so no event is lost while the line is masked. The configuration register also holds a 4-bit mode field. This field is only stored and read back.

Top module: `irq_aggregator`

## Requirements
- R1: The register map is fixed. Flag registers 0..3 are at addresses 0x04..0x07 and enable registers 0..3 are at 0x08..0x0B. Both are 8 bits wide and bit i of register k maps to event input 8*k+i. The configuration register is at 0x0C. Enable registers can be written and read back.
- R2: An event pulse sets its flag bit at the next clock edge only if its enable bit is 1. An event on a disabled source leaves the flag at 0.
- R3: When `rd_i` is high, `rdata_o` shows the addressed register, and `rdata_o` is 0x00 when `rd_i` is low. Reading a flag register returns its current value and clears that register at the clock edge.
- R4: An enabled event that arrives in the same cycle as a read of its flag register leaves that bit set after the clear. The read data shows the value from before the read.
- R5: Configuration bit 4 is the pending bit. It reads as the OR over all flag bits whose enable bit is 1.
- R6: `irq_n_o` is low exactly when the global enable is 1 and the pending bit is 1. Otherwise it is high.
- R7: Clearing the global enable does not stop flag capture. When the global enable is set again, `irq_n_o` goes low if enabled flags were captured in the meantime.
- R8: In the configuration register, bit 6 (global enable) and bits 3:0 (mode) are read/write. Bits 7 and 5 always read 0. Writes to bit 4 have no effect.
- R9: Writes to flag registers have no effect.
- R10: A read of any address outside 0x04..0x0C returns 0x00 and changes no state. A write to such an address also changes no state.
- R11: A synchronous active-high reset clears all flags and enables, sets the global enable to 1 and the mode field to 0000, and leaves `irq_n_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 32 | Event pulses, one per source |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe, one access per high cycle |
| wr_i | input | 1 | Write strobe, one access per high cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while `rd_i` is high |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that each high cycle of `rd_i` or `wr_i` is one complete access, that an event is a level sampled at each edge, and that reset is held for at least one edge. The stimulus never raises both strobes in the same cycle. It changes every input only between edges, on the falling clock. Random events are sparse so that enabled flags both build up and drain. Directed sequences force the read-with-event collision, masked capture under a cleared global enable, and accesses to unmapped and flag addresses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned MODE_W   = 4;
   localparam int unsigned GIE_BIT  = 6;
   localparam int unsigned PEND_BIT = 4;
   typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
   import irq_agg_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  reg_t ev_i,
   input  logic flag_rd_i,
   input  logic en_wr_i,
   input  reg_t wdata_i,
   output reg_t flag_o,
   output reg_t en_o,
   output logic hit_o
);
   reg_t flag_q, en_q, capt;

   assign capt = ev_i & en_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= '0;
         en_q   <= '0;
      end else begin
         flag_q <= (flag_rd_i ? '0 : flag_q) | capt;
         if (en_wr_i) en_q <= wdata_i;
      end
   end

   assign flag_o = flag_q;
   assign en_o   = en_q;
   assign hit_o  = |(flag_q & en_q);

   // R2: a bit can only rise where the source was enabled
   a_r2_masked_source: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(en_q)) == '0));
   // R3: after a read, only bits with a fresh event survive
   a_r3_clear_on_read: assert property (@(posedge clk) disable iff (rst)
      flag_rd_i |=> ((flag_q & ~$past(ev_i & en_q)) == '0));
   // R4: an enabled event is never lost, even with a read
   a_r4_event_kept: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flag_q & $past(ev_i & en_q)) == $past(ev_i & en_q)));
   // R9: without a read, flags never fall
   a_r9_no_clear_without_read: assert property (@(posedge clk) disable iff (rst)
      !flag_rd_i |=> ((~flag_q & $past(flag_q)) == '0));
endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
   import irq_agg_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic wr_i,
   input  reg_t wdata_i,
   input  logic pend_i,
   output logic gie_o,
   output reg_t cfg_o
);
   logic              gie_q;
   logic [MODE_W-1:0] mode_q;
   logic              unused_wbits;

   assign unused_wbits = ^{wdata_i[7], wdata_i[5:4]};

   always_ff @(posedge clk) begin
      if (rst) begin
         gie_q  <= 1'b1;
         mode_q <= '0;
      end else if (wr_i) begin
         gie_q  <= wdata_i[GIE_BIT];
         mode_q <= wdata_i[MODE_W-1:0];
      end
   end

   always_comb begin
      cfg_o              = '0;
      cfg_o[GIE_BIT]     = gie_q;
      cfg_o[PEND_BIT]    = pend_i;
      cfg_o[MODE_W-1:0]  = mode_q;
   end

   assign gie_o = gie_q;

   // R8: configuration state only changes on a write
   a_r8_cfg_stable: assert property (@(posedge clk) disable iff (rst)
      !wr_i |=> ($stable(gie_q) && $stable(mode_q)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned FLAG_BASE   = 4,
   parameter int unsigned EN_BASE     = 8,
   parameter int unsigned CFG_ADDR    = 12,
   parameter bit          REG_IRQ_OUT = 1'b0,
   localparam int unsigned EV_W       = NUM_BANKS * REG_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [EV_W-1:0]   ev_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  rdata_o,
   output logic              irq_n_o
);
   if (NUM_BANKS < 1 || NUM_BANKS > 8)
      $error("NUM_BANKS out of range");
   if (FLAG_BASE + NUM_BANKS > EN_BASE)
      $error("flag window overlaps enable window");
   if (EN_BASE + NUM_BANKS > CFG_ADDR)
      $error("enable window overlaps configuration address");
   if (CFG_ADDR >= (1 << ADDR_W))
      $error("configuration address exceeds address width");

   reg_t                 flag_q [NUM_BANKS];
   reg_t                 en_q   [NUM_BANKS];
   logic [NUM_BANKS-1:0] hit, flag_sel, en_sel;
   logic                 cfg_sel, pend, gie;
   reg_t                 cfg_img, rd_mux;

   assign cfg_sel = (addr_i == ADDR_W'(CFG_ADDR));
   assign pend    = |hit;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] FA = ADDR_W'(FLAG_BASE + b);
      localparam logic [ADDR_W-1:0] EA = ADDR_W'(EN_BASE + b);
      assign flag_sel[b] = (addr_i == FA);
      assign en_sel[b]   = (addr_i == EA);
      irq_bank u_bank (
         .clk       (clk),
         .rst       (rst),
         .ev_i      (ev_i[b*REG_W +: REG_W]),
         .flag_rd_i (rd_i && flag_sel[b]),
         .en_wr_i   (wr_i && en_sel[b]),
         .wdata_i   (wdata_i),
         .flag_o    (flag_q[b]),
         .en_o      (en_q[b]),
         .hit_o     (hit[b])
      );
   end

   irq_cfg u_cfg (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (wr_i && cfg_sel),
      .wdata_i (wdata_i),
      .pend_i  (pend),
      .gie_o   (gie),
      .cfg_o   (cfg_img)
   );

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (flag_sel[b]) rd_mux = rd_mux | flag_q[b];
         if (en_sel[b])   rd_mux = rd_mux | en_q[b];
      end
      if (cfg_sel) rd_mux = rd_mux | cfg_img;
   end

   assign rdata_o = rd_i ? rd_mux : '0;

   if (REG_IRQ_OUT) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (rst) irq_q <= 1'b1;
         else     irq_q <= !(gie && pend);
      end
      assign irq_n_o = irq_q;
      // R6: registered line follows the previous cycle's request
      a_r6_irq_reg: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (irq_n_o == !($past(gie) && $past(pend))));
   end else begin : g_irq_comb
      assign irq_n_o = !(gie && pend);
      // R6: a low line needs the global enable and an enabled bank hit
      a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
         !irq_n_o |-> (gie && (hit != '0)));
   end

   // R3: the read port is silent when no read is issued
   a_r3_idle_rdata: assert property (@(posedge clk) disable iff (rst)
      !rd_i |-> (rdata_o == '0));
   // R8: reserved configuration bits always read zero
   a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_i && cfg_sel) |-> (rdata_o[7] == 1'b0 && rdata_o[5] == 1'b0));
   // R10: only one decoded target per address
   a_r10_single_decode: assert property (@(posedge clk) disable iff (rst)
      1'b1 |-> $onehot0({flag_sel, en_sel, cfg_sel}));
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] ev;
   logic [7:0]  addr, wdata, rdata;
   logic        rd, wr, irq_n;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [7:0] m_flag [4];
   logic [7:0] m_en   [4];
   logic       m_gie;
   logic [3:0] m_mode;

   always #10 clk = ~clk;

   irq_aggregator u0 (
      .clk(clk), .rst(rst), .ev_i(ev), .addr_i(addr), .rd_i(rd),
      .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
   );

   function automatic logic m_pend();
      logic p = 1'b0;
      for (int b = 0; b < 4; b++) p = p | (|(m_flag[b] & m_en[b]));
      return p;
   endfunction

   function automatic logic [7:0] m_read(input logic [7:0] a);
      if (a >= 8'h04 && a <= 8'h07) return m_flag[a - 8'h04];
      if (a >= 8'h08 && a <= 8'h0B) return m_en[a - 8'h08];
      if (a == 8'h0C) return {1'b0, m_gie, 1'b0, m_pend(), m_mode};
      return 8'h00;
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic m_reset();
      for (int b = 0; b < 4; b++) begin m_flag[b] = '0; m_en[b] = '0; end
      m_gie = 1'b1; m_mode = '0;
   endtask

   // drive one cycle, check comb outputs before the edge, then advance the model
   task automatic step(input string req, input logic r, input logic w,
                       input logic [7:0] a, input logic [7:0] d, input logic [31:0] e);
      @(negedge clk);
      rd = r; wr = w; addr = a; wdata = d; ev = e;
      #1;
      if (r) check(req, rdata, m_read(a));
      else   check({req, " idle"}, rdata, 8'h00);
      check({req, " irq"}, {7'd0, irq_n}, {7'd0, !(m_gie && m_pend())});
      @(posedge clk);
      for (int b = 0; b < 4; b++) begin
         if (r && a == 8'h04 + b) m_flag[b] = '0;
         m_flag[b] = m_flag[b] | (e[b*8 +: 8] & m_en[b]);
      end
      if (w && a >= 8'h08 && a <= 8'h0B) m_en[a - 8'h08] = d;
      if (w && a == 8'h0C) begin m_gie = d[6]; m_mode = d[3:0]; end
   endtask

   task automatic idle_step(input string req);
      step(req, 1'b0, 1'b0, 8'h00, 8'h00, 32'h0);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; rd = 0; wr = 0; addr = 0; wdata = 0; ev = 0;
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R11: reset state
      #1; check("R11 irq after reset", {7'd0, irq_n}, 8'h01);
      step("R11 cfg reset", 1'b1, 1'b0, 8'h0C, 8'h00, 32'h0);
      check("R11 cfg value", m_read(8'h0C), 8'h40);
      // R2: disabled source ignored
      step("R2 event on disabled", 1'b0, 1'b0, 8'h00, 8'h00, 32'hFFFF_FFFF);
      step("R2 flag stays 0", 1'b1, 1'b0, 8'h04, 8'h00, 32'h0);
      // R1: enable write and read back
      step("R1 write enable0", 1'b0, 1'b1, 8'h08, 8'h81, 32'h0);
      step("R1 read enable0", 1'b1, 1'b0, 8'h08, 8'h00, 32'h0);
      step("R1 write enable3", 1'b0, 1'b1, 8'h0B, 8'h10, 32'h0);
      // R6: event raises the line
      step("R6 event bit0", 1'b0, 1'b0, 8'h00, 8'h00, 32'h0000_0001);
      idle_step("R6 irq low");
      // R5: pending visible
      step("R5 pending read", 1'b1, 1'b0, 8'h0C, 8'h00, 32'h0);
      // R9: flag writes ignored
      step("R9 write flag0", 1'b0, 1'b1, 8'h04, 8'h00, 32'h0);
      // R10: unmapped accesses
      step("R10 write 0x0D", 1'b0, 1'b1, 8'h0D, 8'hFF, 32'h0);
      step("R10 read 0x03", 1'b1, 1'b0, 8'h03, 8'h00, 32'h0);
      step("R10 read 0x0D", 1'b1, 1'b0, 8'h0D, 8'h00, 32'h0);
      // R4: event collides with read
      step("R4 read with event", 1'b1, 1'b0, 8'h04, 8'h00, 32'h0000_0080);
      step("R4 bit kept", 1'b1, 1'b0, 8'h04, 8'h00, 32'h0);
      // R3: cleared
      step("R3 flag cleared", 1'b1, 1'b0, 8'h04, 8'h00, 32'h0);
      // R7: capture while masked
      step("R7 clear gie", 1'b0, 1'b1, 8'h0C, 8'h05, 32'h0);
      step("R7 event masked", 1'b0, 1'b0, 8'h00, 8'h00, 32'h1000_0000);
      idle_step("R7 irq high while masked");
      step("R8 cfg readback", 1'b1, 1'b0, 8'h0C, 8'h00, 32'h0);
      step("R7 set gie", 1'b0, 1'b1, 8'h0C, 8'hFF, 32'h0);
      idle_step("R7 irq low after unmask");
      step("R8 reserved bits", 1'b1, 1'b0, 8'h0C, 8'h00, 32'h0);
      step("R3 drain bank3", 1'b1, 1'b0, 8'h07, 8'h00, 32'h0);
      idle_step("R6 irq released");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int unsigned k = $urandom_range(0, 9);
         logic [7:0] a = 8'($urandom_range(0, 15));
         logic [31:0] e = $urandom & $urandom & $urandom;
         if (k < 4)      step("R3 random read", 1'b1, 1'b0, a, 8'h00, e);
         else if (k < 6) step("R1 random write", 1'b0, 1'b1, a, 8'($urandom), e);
         else            step("R2 random idle", 1'b0, 1'b0, a, 8'h00, e);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule